// File: doc/BRIEF.md
# Burst-Write Hit FIFO

This block is a first-in first-out buffer for detector hit words. Its write side is wider than its read side. In one clock cycle a producer offers up to eight hit words on parallel lanes, together with a count of how many lanes carry data. The read side hands out one word per clock through a valid/ready handshake.

Instances can be arranged in a two-level tree. Small lower-level buffers (typically 8 entries) each feed a larger upper-level buffer (typically 32 entries). At each level the producer widens the word with a 2-bit index saying which lower branch it came from. In a full tree, a 22-bit hit therefore holds a 2-bit upper index, a 2-bit lower index, a 7-bit column, a 3-bit zone and an 8-bit pixel pattern. This block only carries words of a parameterised width; it does not read or change their contents.

Bursts can exceed the free space even when the average input rate is below one word per clock. For this reason the block counts the groups it drops and tracks both the highest fill level and a smoothed fill level, so that the depth can be tuned.

Top module: `hit_burst_fifo`

## Requirements
- R1: After reset:
  - the buffer is empty: `empty`=1, `full`=0, `rd_valid`=0;
  - `ovf_count`, `max_fill` and `mean_fill` are all zero.
- R2: A write of N words (`wr_cnt`=N, 1 to 8) stores lanes 0 to N-1. Lane i is `wr_data[i*W +: W]`. Words leave in lane order within a group and in cycle order across groups.
- R3: `rd_valid` is 1 exactly when the buffer holds at least one word, and `rd_data` is then the oldest word. A cycle with `rd_valid` and `rd_ready` both high removes exactly one word. While `rd_ready` is low, the head word stays on `rd_data` unchanged.
- R4: A group of N words is accepted only if N is no greater than DEPTH minus the current fill, plus one when a read completes in the same cycle. Otherwise the whole group is dropped and the stored contents are unchanged.
- R5: `ovf_count` rises by one for each dropped group. It saturates at its all-ones value.
- R6: `full` is 1 exactly when the fill equals DEPTH. `empty` is 1 exactly when the fill is zero.
- R7: `max_fill` is the highest fill level seen after any clock edge since reset. It never decreases.
- R8: `mean_fill` is the integer part of acc/2^SH. After each clock edge, acc is updated from its old value as acc + fill − floor(acc/2^SH), where fill is the level before that edge, and acc is zero after reset.
- R9: `wr_cnt`=0 stores nothing and never counts as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_cnt | input | CW | Number of valid lanes this cycle (0 to LANES) |
| wr_data | input | LANES*W | Lane words; lane 0 in the low bits |
| rd_ready | input | 1 | Consumer takes the head word |
| rd_data | output | W | Head word |
| rd_valid | output | 1 | Head word present |
| full | output | 1 | Fill equals DEPTH |
| empty | output | 1 | Fill is zero |
| ovf_count | output | OVF_W | Saturating count of dropped groups |
| max_fill | output | AW+1 | Highest fill reached |
| mean_fill | output | AW+1 | Smoothed fill level |

## Verification
The assertions assume that `wr_cnt` never exceeds the lane count. They also assume that `rd_ready` may be held low for any length of time and that the buffer must then keep its head word. The bench keeps `wr_cnt` within 0 to 8 in both phases. The first phase is an exhaustive sweep: for every starting fill level, every group size and both read states, it applies one write and then drains the buffer. The second phase draws its group sizes as a pseudo-random value modulo nine, on a small 8-entry, 8-bit configuration.

// File: rtl/hit_burst_fifo.sv
module hit_burst_fifo #(
  parameter int W     = 22,
  parameter int DEPTH = 32,
  parameter int LANES = 8,
  parameter int CW    = $clog2(LANES + 1),
  parameter int OVF_W = 16,
  parameter int SH    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CW-1:0]        wr_cnt,
  input  logic [LANES*W-1:0]   wr_data,
  input  logic                 rd_ready,
  output logic [W-1:0]         rd_data,
  output logic                 rd_valid,
  output logic                 full,
  output logic                 empty,
  output logic [OVF_W-1:0]     ovf_count,
  output logic [$clog2(DEPTH):0] max_fill,
  output logic [$clog2(DEPTH):0] mean_fill
);
  localparam int AW = $clog2(DEPTH);
  localparam int FW = AW + 1;

  logic [W-1:0]     mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [FW-1:0]    fill;
  logic [FW+SH-1:0] acc;
  logic [FW:0]      room, nxt;
  logic             rd_fire, accept;

  assign rd_valid  = (fill != '0);
  assign empty     = (fill == '0);
  assign full      = (fill == FW'(DEPTH));
  assign rd_data   = mem[rp];
  assign rd_fire   = rd_valid & rd_ready;
  assign room      = (FW+1)'(DEPTH) - {1'b0, fill} + (FW+1)'(rd_fire);
  assign accept    = (wr_cnt != '0) && ((FW+1)'(wr_cnt) <= room);
  assign nxt       = {1'b0, fill} + (accept ? (FW+1)'(wr_cnt) : '0) - (FW+1)'(rd_fire);
  assign mean_fill = FW'(acc >> SH);

  always_ff @(posedge clk) begin
    if (accept)
      for (int i = 0; i < LANES; i++)
        if (i < int'(wr_cnt))
          mem[wp + AW'(i)] <= wr_data[i*W +: W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp        <= '0;
      rp        <= '0;
      fill      <= '0;
      acc       <= '0;
      max_fill  <= '0;
      ovf_count <= '0;
    end else begin
      fill <= nxt[FW-1:0];
      acc  <= acc + (FW+SH)'(fill) - (acc >> SH);
      if (accept) wp <= wp + AW'(wr_cnt);
      if (rd_fire) rp <= rp + 1'b1;
      if (nxt[FW-1:0] > max_fill) max_fill <= nxt[FW-1:0];
      if (wr_cnt != '0 && !accept && ovf_count != '1)
        ovf_count <= ovf_count + 1'b1;
    end
  end
endmodule

// File: rtl/hit_burst_fifo_chk.sv
module hit_burst_fifo_chk #(
  parameter int DEPTH = 32,
  parameter int LANES = 8,
  parameter int W     = 22,
  parameter int CW    = 4,
  parameter int OVF_W = 16,
  parameter int FW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] wr_cnt,
  input logic          rd_ready,
  input logic [W-1:0]  rd_data,
  input logic          rd_valid,
  input logic          full,
  input logic          empty,
  input logic [OVF_W-1:0] ovf_count,
  input logic [FW-1:0] max_fill,
  input logic [FW-1:0] mean_fill,
  input logic [FW-1:0] fill
);
  AST_CNT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    int'(wr_cnt) <= LANES); // R2
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R3
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    full && !rd_ready && wr_cnt != '0 && ovf_count != '1 |=> ovf_count == OVF_W'($past(ovf_count) + 1'b1)); // R4
  AST_OVF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ovf_count == $past(ovf_count) || ovf_count == OVF_W'($past(ovf_count) + 1'b1)); // R5
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty)); // R6
  AST_MAX_MONO: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> max_fill >= $past(max_fill)); // R7
  AST_MAX_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    max_fill >= fill); // R7
  AST_MEAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mean_fill) <= DEPTH); // R8
  AST_IDLE_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt == '0 |=> ovf_count == $past(ovf_count)); // R9
endmodule

bind hit_burst_fifo hit_burst_fifo_chk #(
  .DEPTH(DEPTH), .LANES(LANES), .W(W), .CW(CW), .OVF_W(OVF_W), .FW(FW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .rd_ready(rd_ready),
  .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
  .ovf_count(ovf_count), .max_fill(max_fill), .mean_fill(mean_fill), .fill(fill)
);

// File: tb/hit_burst_fifo_tb.sv
module hit_burst_fifo_tb;
  localparam int W = 8, DEPTH = 8, LANES = 8, CW = 4, OVF_W = 4, SH = 2;
  localparam int FW = 4;

  logic clk = 0, rst_n = 0, rd_ready = 0;
  logic [CW-1:0] wr_cnt = '0;
  logic [LANES*W-1:0] wr_data = '0;
  logic [W-1:0] rd_data;
  logic rd_valid, full, empty;
  logic [OVF_W-1:0] ovf_count;
  logic [FW-1:0] max_fill, mean_fill;

  hit_burst_fifo #(.W(W), .DEPTH(DEPTH), .LANES(LANES), .CW(CW), .OVF_W(OVF_W), .SH(SH)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_cnt(wr_cnt), .wr_data(wr_data), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_valid(rd_valid), .full(full), .empty(empty),
    .ovf_count(ovf_count), .max_fill(max_fill), .mean_fill(mean_fill));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] q[$];
  int m_ovf, m_max, m_acc;
  logic [7:0] seq = 8'h01;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; wr_cnt = '0; rd_ready = 0;
    q.delete(); m_ovf = 0; m_max = 0; m_acc = 0;
    @(posedge clk); @(negedge clk);
    rst_n = 1;
    chk(empty && !full && !rd_valid, "R1 flags", {29'd0, empty, full, rd_valid}, 4);
    chk(ovf_count == 0 && max_fill == 0 && mean_fill == 0, "R1 stats",
        int'(ovf_count) + int'(max_fill) + int'(mean_fill), 0);
  endtask

  task automatic step(input int n, input bit rdy);
    int room; bit fire; int sz;
    @(negedge clk);
    sz = q.size();
    chk(rd_valid == (sz > 0), "R3 valid", int'(rd_valid), int'(sz > 0));
    if (sz > 0) chk(rd_data == q[0], "R2 order/head data", int'(rd_data), int'(q[0]));
    chk(full == (sz == DEPTH) && empty == (sz == 0), "R6 flags", {30'd0, full, empty},
        {30'd0, sz == DEPTH, sz == 0});
    chk(int'(ovf_count) == m_ovf, "R5 ovf_count", int'(ovf_count), m_ovf);
    chk(int'(max_fill) == m_max, "R7 max_fill", int'(max_fill), m_max);
    chk(int'(mean_fill) == (m_acc >> SH), "R8 mean_fill", int'(mean_fill), m_acc >> SH);
    wr_cnt = CW'(n); rd_ready = rdy;
    for (int i = 0; i < LANES; i++) wr_data[i*W +: W] = seq + 8'(i);
    fire = rdy && sz > 0;
    room = DEPTH - sz + int'(fire);
    m_acc = m_acc + sz - (m_acc >> SH);
    if (fire) void'(q.pop_front());
    if (n > 0) begin
      if (n <= room) begin
        for (int i = 0; i < n; i++) q.push_back(seq + 8'(i));
        seq = seq + 8'(n);
      end else if (m_ovf < (1 << OVF_W) - 1) m_ovf++;   // R4 whole group dropped
    end
    if (q.size() > m_max) m_max = q.size();
    @(posedge clk);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R4 R9 sweep: every start fill, every group size, both read states
    for (int f = 0; f <= DEPTH; f++)
      for (int n = 0; n <= LANES; n++)
        for (int r = 0; r < 2; r++) begin
          while (q.size() < f) step(1, 0);
          step(n, r[0]);
          step(0, 0);
          while (q.size() > 0) step(0, 1);
        end
    step(0, 0);
    do_reset();
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(int'(lfsr[7:0]) % 9, lfsr[9] | lfsr[11]);
    end
    while (q.size() > 0) step(0, 1);
    step(0, 0);
    finish_run();
  end
endmodule